// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations in a small fully associative array. A requester presents a virtual page number, the page offset, an access type (read or write) and the privilege level (kernel or user). In the same cycle the block compares the page number against every stored entry and reports one of three outcomes.

- **Hit:** the block returns the physical address, which is the stored physical page number joined to the unchanged offset.
- **Protection fault:** the access breaks the permissions of the matching entry.
- **Miss:** the block raises a refill request toward an external page-table walker.

The walker answers with a fill entry. The block writes that entry into the array. It picks the slot in this order:

1. the slot already holding the same page number, if any;
2. otherwise the lowest-numbered empty slot;
3. otherwise a victim chosen by a per-entry reference bit.

A flush input empties the whole array in one cycle. It is used when the active address space changes.

Each entry holds these fields:

- valid bit
- read permission
- write permission
- dirty bit
- kernel-only flag
- page-number tag
- physical page number

A write to a writable entry whose dirty bit is clear is reported as a miss. This lets the walker mark the page dirty in memory and refill the entry.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so any request gives `resp_hit`=0, `resp_fault`=0 and `refill_req`=1.
- R2: On a hit, `resp_paddr` equals {stored PPN, `req_off`} in the same cycle as the request. When there is no hit, `resp_paddr` is 0.
- R3: A request whose page number matches no valid entry gives `refill_req`=1 with `refill_vpn`=`req_vpn`, and `resp_hit`=0, `resp_fault`=0.
- R4: A fill (`fill_valid`=1 without flush) is written at the clock edge, so a request for that page number in the next cycle hits.
- R5: A user-mode access (`req_user`=1) to an entry whose kernel-only flag is set raises `resp_fault` and gives neither hit nor refill.
- R6: A write to an entry without write permission faults, and so does a read of an entry without read permission.
- R7: A write to a writable entry with the dirty bit clear gives `refill_req`=1 with no fault and no hit, while a read of that entry hits. A fill with the same page number replaces that entry in place.
- R8: `flush`=1 invalidates every entry in one cycle and takes precedence over a fill in the same cycle.
- R9: While an empty slot exists, a fill of a new page number goes to the lowest-numbered empty slot.
- R10: Each entry has a reference bit that is set by a hit or a fill of that entry. When all reference bits would become set, all are cleared. With no empty slot, a fill of a new page number replaces the lowest-numbered entry whose reference bit is clear.
- R11: A kernel-mode access to a kernel-only entry with the needed permission hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | 20 | Virtual page number to translate |
| req_off | input | 12 | Page offset, passed through untranslated |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| resp_hit | output | 1 | Translation valid this cycle |
| resp_fault | output | 1 | Protection check failed |
| resp_paddr | output | 32 | Physical address on hit, else 0 |
| refill_req | output | 1 | Request to the walker for this page |
| refill_vpn | output | 20 | Page number the walker should look up |
| fill_valid | input | 1 | Fill entry from the walker present |
| fill_vpn | input | 20 | Page number of the fill entry |
| fill_ppn | input | 20 | Physical page number of the fill entry |
| fill_rd | input | 1 | Read permission of the fill entry |
| fill_wr | input | 1 | Write permission of the fill entry |
| fill_dirty | input | 1 | Dirty bit of the fill entry |
| fill_kern | input | 1 | Kernel-only flag of the fill entry |

## Verification
The victim choice is the hardest part to reach from the ports. It only matters once every slot is full, and its outcome depends on reference bits that are never visible.

The stimulus first fills all sixteen slots in order. The sixteenth fill sets the last reference bit, which clears them all. The bench then hits three chosen entries and inserts a new page. It observes the eviction as a miss on the fourth page while its neighbours still hit.

A second round of hits sets the remaining reference bits and forces the wrap-around clear. A further fill must then displace slot zero.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int OFF_W = 12;
    localparam int PA_W = PPN_W + OFF_W;

    typedef struct packed {
        logic             kern_only;
        logic             can_rd;
        logic             can_wr;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlat_ent_t;

    typedef struct packed {
        logic fault;
        logic upgrade;
    } perm_res_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  xlat_ent_t [ENTRIES-1:0] ents,
    input  logic [ENTRIES-1:0]      valid,
    input  logic [VPN_W-1:0]        key,
    output logic [ENTRIES-1:0]      match,
    output logic                    any,
    output xlat_ent_t               sel
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (ents[g].vpn == key);
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) sel = sel | ents[i];
        end
    end

    assign any = |match;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  xlat_ent_t ent,
    input  logic      is_wr,
    input  logic      is_user,
    output perm_res_t res
);
    always_comb begin
        res.fault   = (is_user && ent.kern_only)
                    || (is_wr && !ent.can_wr)
                    || (!is_wr && !ent.can_rd);
        res.upgrade = is_wr && ent.can_wr && !ent.dirty;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] ref_bits,
    input  logic [ENTRIES-1:0] same_vpn,
    output logic [IDX_W-1:0]   slot
);
    function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        if (|same_vpn)        slot = lowest(same_vpn);
        else if (!(&valid))   slot = lowest(~valid);
        else                  slot = lowest(~ref_bits);
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_write,
    input  logic             req_user,
    output logic             resp_hit,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             refill_req,
    output logic [VPN_W-1:0] refill_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_dirty,
    input  logic             fill_kern
);
    xlat_ent_t [ENTRIES-1:0] ents_q;
    logic [ENTRIES-1:0]      valid_q;
    logic [ENTRIES-1:0]      ref_q;
    logic [ENTRIES-1:0]      ref_nxt;

    logic [ENTRIES-1:0]      req_match;
    logic                    req_any;
    xlat_ent_t               req_ent;
    logic [ENTRIES-1:0]      fill_match;
    logic                    fill_any;
    xlat_ent_t               fill_sel_unused;
    perm_res_t               perm;
    logic [IDX_W-1:0]        fill_slot;
    xlat_ent_t               fill_ent;

    tlb_cam #(.ENTRIES(ENTRIES)) req_cam_i (
        .ents(ents_q), .valid(valid_q), .key(req_vpn),
        .match(req_match), .any(req_any), .sel(req_ent)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) fill_cam_i (
        .ents(ents_q), .valid(valid_q), .key(fill_vpn),
        .match(fill_match), .any(fill_any), .sel(fill_sel_unused)
    );

    tlb_perm perm_i (
        .ent(req_ent), .is_wr(req_write), .is_user(req_user), .res(perm)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .valid(valid_q), .ref_bits(ref_q), .same_vpn(fill_match), .slot(fill_slot)
    );

    always_comb begin
        resp_fault = req_valid && req_any && perm.fault;
        resp_hit   = req_valid && req_any && !perm.fault && !perm.upgrade;
        refill_req = req_valid && !resp_fault && !resp_hit;
        refill_vpn = refill_req ? req_vpn : '0;
        resp_paddr = resp_hit ? {req_ent.ppn, req_off} : '0;
    end

    always_comb begin
        fill_ent = '{kern_only: fill_kern, can_rd: fill_rd, can_wr: fill_wr,
                     dirty: fill_dirty, vpn: fill_vpn, ppn: fill_ppn};
        ref_nxt = ref_q;
        if (resp_hit) ref_nxt = ref_nxt | req_match;
        if (fill_valid) ref_nxt[fill_slot] = 1'b1;
        if (&ref_nxt) ref_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
            ref_q   <= '0;
        end else begin
            ref_q <= ref_nxt;
            if (fill_valid) valid_q[fill_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid && !flush && !rst) ents_q[fill_slot] <= fill_ent;
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, fill_any, fill_sel_unused};
endmodule

// File: rtl/tlb_sva.sv
module tlb_sva
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               fill_valid,
    input logic               req_valid,
    input logic [OFF_W-1:0]   req_off,
    input logic               resp_hit,
    input logic               resp_fault,
    input logic               refill_req,
    input logic [PA_W-1:0]    resp_paddr,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] ref_q,
    input logic [ENTRIES-1:0] req_match
);
    p_reset_empty_r1: assert property (@(posedge clk)
        $past(rst) |-> valid_q == '0);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_paddr[OFF_W-1:0] == req_off);

    p_miss_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> (!resp_hit && !resp_fault && req_valid));

    p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_match));

    p_fill_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !flush) |=> valid_q != '0);

    p_fault_no_hit_r5: assert property (@(posedge clk) disable iff (rst)
        !(resp_hit && resp_fault));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0 && ref_q == '0));

    p_ref_never_full_r10: assert property (@(posedge clk) disable iff (rst)
        !(&ref_q));
endmodule

bind tlb_top tlb_sva #(.ENTRIES(ENTRIES)) sva_i (
    .clk(clk), .rst(rst), .flush(flush), .fill_valid(fill_valid),
    .req_valid(req_valid), .req_off(req_off), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .refill_req(refill_req), .resp_paddr(resp_paddr),
    .valid_q(valid_q), .ref_q(ref_q), .req_match(req_match)
);

// File: tb/tlb_top_tb_top.sv
`timescale 1ns/1ps
module tlb_top_tb_top;
    import tlb_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             req_write = 1'b0;
    logic             req_user = 1'b0;
    logic             resp_hit, resp_fault, refill_req;
    logic [PA_W-1:0]  resp_paddr;
    logic [VPN_W-1:0] refill_vpn;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_rd = 1'b0, fill_wr = 1'b0, fill_dirty = 1'b0, fill_kern = 1'b0;

    always #2.5 clk = ~clk;

    tlb_top dut_i (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
        .req_vpn(req_vpn), .req_off(req_off), .req_write(req_write),
        .req_user(req_user), .resp_hit(resp_hit), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .refill_req(refill_req), .refill_vpn(refill_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_dirty(fill_dirty),
        .fill_kern(fill_kern)
    );

    typedef struct {
        string            tag;
        logic             hit;
        logic             fault;
        logic             refill;
        logic [PA_W-1:0]  paddr;
        logic [VPN_W-1:0] vpn;
    } exp_t;

    exp_t  sb_q[$];
    event  drv_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    task automatic access(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input logic wr, input logic usr, input logic e_hit,
                          input logic e_fault, input logic [PPN_W-1:0] e_ppn,
                          input string tag);
        exp_t e;
        @(negedge clk);
        fill_valid = 1'b0;
        flush      = 1'b0;
        req_valid  = 1'b1;
        req_vpn    = vpn;
        req_off    = off;
        req_write  = wr;
        req_user   = usr;
        e.tag    = tag;
        e.hit    = e_hit;
        e.fault  = e_fault;
        e.refill = !e_hit && !e_fault;
        e.paddr  = e_hit ? {e_ppn, off} : '0;
        e.vpn    = vpn;
        sb_q.push_back(e);
        -> drv_ev;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic rd, input logic wr, input logic dty,
                        input logic kern, input logic fl);
        @(negedge clk);
        req_valid  = 1'b0;
        fill_valid = 1'b1;
        flush      = fl;
        fill_vpn   = vpn;
        fill_ppn   = ppn;
        fill_rd    = rd;
        fill_wr    = wr;
        fill_dirty = dty;
        fill_kern  = kern;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid  = 1'b0;
        fill_valid = 1'b0;
        flush      = 1'b0;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(drv_ev);
            #1;
            e = sb_q.pop_front();
            n_chk++;
            if (resp_hit !== e.hit || resp_fault !== e.fault || refill_req !== e.refill
                || resp_paddr !== e.paddr || (e.refill && refill_vpn !== e.vpn)) begin
                n_fail++;
                $display("FAIL %s: hit/fault/refill=%b%b%b paddr=%h rvpn=%h, expected %b%b%b paddr=%h rvpn=%h",
                         e.tag, resp_hit, resp_fault, refill_req, resp_paddr, refill_vpn,
                         e.hit, e.fault, e.refill, e.paddr, e.vpn);
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        access(20'h00005, 12'h010, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R1 reset miss");

        // R4 / R2: fill slot 0, then hit with offset
        fill(20'h00100, 20'h000AB, 1, 1, 1, 0, 0);
        access(20'h00100, 12'h345, 1'b0, 1'b1, 1'b1, 1'b0, 20'h000AB, "R2 R4 read hit");
        access(20'h00100, 12'hFFF, 1'b1, 1'b1, 1'b1, 1'b0, 20'h000AB, "R2 write hit");

        // R3: unknown page
        access(20'h00222, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 miss");

        // R5 / R11: kernel-only entry in slot 1
        fill(20'h00101, 20'h00C01, 1, 1, 1, 1, 0);
        access(20'h00101, 12'h020, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R5 user to kernel");
        access(20'h00101, 12'h020, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00C01, "R11 kernel hit");

        // R6: read-only in slot 2, write-only in slot 3
        fill(20'h00102, 20'h00C02, 1, 0, 1, 0, 0);
        fill(20'h00103, 20'h00C03, 0, 1, 1, 0, 0);
        access(20'h00102, 12'h030, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R6 write no perm");
        access(20'h00103, 12'h030, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R6 read no perm");

        // R7: clean writable entry in slot 4
        fill(20'h00104, 20'h00C04, 1, 1, 0, 0, 0);
        access(20'h00104, 12'h040, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7 clean write miss");
        access(20'h00104, 12'h040, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00C04, "R7 clean read hit");
        fill(20'h00104, 20'h00C44, 1, 1, 1, 0, 0);
        access(20'h00104, 12'h041, 1'b1, 1'b1, 1'b1, 1'b0, 20'h00C44, "R7 dirty write hit");

        // fill slots 5..15; the last fill clears all reference bits
        for (int i = 5; i < 16; i++) begin
            fill(20'h00100 + VPN_W'(i), 20'h00D00 + PPN_W'(i), 1, 1, 1, 0, 0);
        end

        // R10 / R9: touch slots 0..2, new page must displace slot 3
        access(20'h00100, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h000AB, "R10 touch 0");
        access(20'h00101, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00C01, "R10 touch 1");
        access(20'h00102, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00C02, "R10 touch 2");
        fill(20'h00200, 20'h00E00, 1, 1, 1, 0, 0);
        access(20'h00103, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 R10 slot3 evicted");
        access(20'h00200, 12'h123, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00E00, "R10 new page hit");
        access(20'h00104, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00C44, "R10 slot4 kept");

        // R10: set remaining bits, wrap clears, next victim is slot 0
        for (int i = 5; i < 16; i++) begin
            access(20'h00100 + VPN_W'(i), 12'h0, 1'b0, 1'b0, 1'b1, 1'b0,
                   20'h00D00 + PPN_W'(i), "R10 touch rest");
        end
        fill(20'h00300, 20'h00F00, 1, 1, 1, 0, 0);
        access(20'h00100, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 wrap slot0 evicted");
        access(20'h00300, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00F00, "R10 wrap new hit");
        access(20'h00101, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00C01, "R10 wrap slot1 kept");

        // R8: flush beats simultaneous fill
        fill(20'h00400, 20'h00A00, 1, 1, 1, 0, 1);
        access(20'h00101, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 flushed entry");
        access(20'h00400, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 fill dropped");
        fill(20'h00500, 20'h00B00, 1, 1, 1, 0, 0);
        access(20'h00500, 12'h7, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00B00, "R4 refill after flush");

        idle();
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule